// File: doc/BRIEF.md
# Coalescing Address-Only Write-Back Queue

This block sits between a data cache and a shared memory bus and schedules dirty cache lines for write-back. Each queue slot stores only a line address. The line data stays in the cache, where processor reads can still hit it. The data is read from the cache only when the slot reaches the front of the queue and is offered to the bus. Because of this, a line that the processor rewrites while it waits goes out with its newest contents.

The processor side presents a write-back address with `wb_valid`. The queue compares that address against every occupied slot in the same cycle. When the address is already queued, the request folds into the existing slot, so that line gets only one bus write. When every slot is occupied and the address is new, `wb_stall` holds the processor until a slot frees. The bus side offers the oldest slot with `bus_req`. It drives the cache read port with that slot's address and passes the returned line to `bus_data`. A cycle with `bus_gnt` high completes the write and frees the slot.

Top module: `wb_tag_queue`

## Requirements
- R1: After reset no slot is occupied, `wb_stall` is low and `bus_req` is low.
- R2: Queued addresses are offered on `bus_addr` in the order in which they were accepted. While `bus_req` is high and `bus_gnt` is low, `bus_addr` holds its value.
- R3: Each occupied slot produces exactly one granted bus write, and `bus_gnt` frees it. `bus_req` is high exactly when at least one slot is occupied.
- R4: A request whose address equals an occupied slot that is not leaving in that cycle takes no new slot and causes no extra bus write.
- R5: The queue holds exactly DEPTH addresses (2 to 4, default 4). With every slot occupied, a request for a new address raises `wb_stall` in the same cycle. `wb_stall` stays high until a slot drains.
- R6: A request that combines with an occupied slot never stalls, even when the queue is full.
- R7: `bus_data` is the cache line returned on `rd_data` for `rd_addr`, which equals `bus_addr` while `rd_en` is high. The bus therefore carries the line's contents at drain time, including writes made after the line was queued.
- R8: When the queue is full and a grant frees the front slot in the same cycle, a new-address request is accepted without stalling.
- R9: A request whose address equals the front slot while that slot is being granted takes a new slot, so that address is written on the bus a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Processor presents a write-back request |
| wb_addr | input | ADDR_W | Line address of the request |
| wb_stall | output | 1 | Request not accepted this cycle; hold it |
| bus_req | output | 1 | Front slot is offered to the bus |
| bus_addr | output | ADDR_W | Line address of the front slot |
| bus_data | output | DATA_W | Line data read from the cache for the front slot |
| bus_gnt | input | 1 | Bus accepts the offered write this cycle |
| rd_en | output | 1 | Cache data-read enable |
| rd_addr | output | ADDR_W | Cache data-read line address |
| rd_data | input | DATA_W | Cache line data, combinational from `rd_addr` |

## Verification
The assertions check on every cycle that occupancy stays within DEPTH and matches the number of occupied slots, and that `bus_req` follows occupancy. They also check that stalls occur only with a full queue and a pending request, and that the offered address holds while the grant is withheld. Only the bench scenarios can show the rest. These are the drain order, that a combined address is written once, and that a line rewritten after queueing drains with its new contents. They also cover the two same-cycle cases: a full queue accepting during a grant, and a request matching a front slot that is leaving.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
   localparam int unsigned WBQ_MIN_DEPTH = 2;
   localparam int unsigned WBQ_MAX_DEPTH = 4;

   // circular advance of a slot index
   function automatic int unsigned wbq_next(input int unsigned idx, input int unsigned depth);
      return (idx == depth - 1) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/wbq_ptr.sv
module wbq_ptr #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic [CNT_W-1:0] occ_cnt,
   output logic             full
);
   import wbq_pkg::*;

   logic [IDX_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= IDX_W'(wbq_next(int'(tail_q), DEPTH));
         if (pop)  head_q <= IDX_W'(wbq_next(int'(head_q), DEPTH));
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_idx = head_q;
   assign tail_idx = tail_q;
   assign occ_cnt  = cnt_q;
   assign full     = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/wbq_slots.sv
module wbq_slots #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 8,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [IDX_W-1:0]             tail_idx,
   input  logic [ADDR_W-1:0]            push_addr,
   input  logic                         pop,
   input  logic [IDX_W-1:0]             head_idx,
   output logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
   output logic [DEPTH-1:0]             slot_vld
);
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic             vld_q;
      logic [ADDR_W-1:0] addr_q;
      logic             set_w, clr_w;

      assign set_w = push && (tail_idx == IDX_W'(s));
      assign clr_w = pop  && (head_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
         end else if (set_w) begin
            // a freed slot may be refilled in the same cycle
            vld_q  <= 1'b1;
            addr_q <= push_addr;
         end else if (clr_w) begin
            vld_q  <= 1'b0;
         end
      end

      assign slot_vld[s]  = vld_q;
      assign slot_addr[s] = addr_q;
   end
endmodule

// File: rtl/wbq_match.sv
module wbq_match #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 8
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
   input  logic [DEPTH-1:0]             slot_vld,
   input  logic [DEPTH-1:0]             leaving,
   input  logic [ADDR_W-1:0]            probe_addr,
   output logic                         hit
);
   logic [DEPTH-1:0] hit_vec;

   // one comparator per slot, all in parallel
   for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
      assign hit_vec[s] = slot_vld[s] && !leaving[s] && (slot_addr[s] == probe_addr);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/wb_tag_queue.sv
module wb_tag_queue #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_valid,
   input  logic [ADDR_W-1:0] wb_addr,
   output logic              wb_stall,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   input  logic              bus_gnt,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data
);
   import wbq_pkg::*;

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < WBQ_MIN_DEPTH || DEPTH > WBQ_MAX_DEPTH) begin : g_bad_depth
      $error("wb_tag_queue: DEPTH must lie in 2..4");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("wb_tag_queue: ADDR_W and DATA_W must be positive");
   end

   logic [IDX_W-1:0]             head_idx, tail_idx;
   logic [CNT_W-1:0]             occ_cnt;
   logic                         full;
   logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
   logic [DEPTH-1:0]             slot_vld;
   logic [DEPTH-1:0]             leaving;
   logic                         hit, push, pop;

   assign bus_req  = slot_vld[head_idx];
   assign pop      = bus_req && bus_gnt;
   assign leaving  = pop ? (DEPTH'(1) << head_idx) : '0;
   assign push     = wb_valid && !hit && (!full || pop);
   assign wb_stall = wb_valid && !hit && full && !pop;

   assign bus_addr = slot_addr[head_idx];
   assign rd_en    = bus_req;
   assign rd_addr  = bus_addr;
   assign bus_data = rd_data;

   wbq_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .pop      (pop),
      .head_idx (head_idx),
      .tail_idx (tail_idx),
      .occ_cnt  (occ_cnt),
      .full     (full)
   );

   wbq_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .tail_idx  (tail_idx),
      .push_addr (wb_addr),
      .pop       (pop),
      .head_idx  (head_idx),
      .slot_addr (slot_addr),
      .slot_vld  (slot_vld)
   );

   wbq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
      .slot_addr  (slot_addr),
      .slot_vld   (slot_vld),
      .leaving    (leaving),
      .probe_addr (wb_addr),
      .hit        (hit)
   );
endmodule

// File: rtl/wb_tag_queue_chk.sv
module wb_tag_queue_chk #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wb_valid,
   input logic              wb_stall,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  occ_cnt,
   input logic [DEPTH-1:0]  slot_vld
);
   // R3: counter never exceeds capacity
   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      occ_cnt <= CNT_W'(DEPTH));

   // R3: counter agrees with occupied slots
   a_r3_cnt_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(slot_vld) == int'(occ_cnt));

   // R3: request tracks occupancy
   a_r3_req_when_occupied: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req == (occ_cnt != '0));

   // R5: stall only for a pending request on a full queue
   a_r5_stall_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      wb_stall |-> (wb_valid && occ_cnt == CNT_W'(DEPTH)));

   // R2: offered address held until granted
   a_r2_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));

   // R8: a grant on a full queue never leaves the request stalled
   a_r8_gnt_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt) |-> !wb_stall);
endmodule

bind wb_tag_queue wb_tag_queue_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wb_valid (wb_valid),
   .wb_stall (wb_stall),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .bus_addr (bus_addr),
   .occ_cnt  (occ_cnt),
   .slot_vld (slot_vld)
);

// File: tb/tb_wb_tag_queue.sv
`timescale 1ns/1ps
module tb_wb_tag_queue;
   localparam int unsigned DEPTH  = 4;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wb_valid = 1'b0;
   logic [ADDR_W-1:0] wb_addr = '0;
   logic              wb_stall;
   logic              bus_req;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_data;
   logic              bus_gnt = 1'b0;
   logic              rd_en;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;

   logic [DATA_W-1:0] cmem [16];
   assign rd_data = cmem[rd_addr[3:0]];

   int n_cmp = 0;
   int n_bad = 0;
   logic [ADDR_W-1:0] exp_q [$];
   logic [DATA_W-1:0] last_data;
   bit done = 0;

   always #2.5 clk = ~clk;

   wb_tag_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .wb_stall(wb_stall), .bus_req(bus_req), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_gnt(bus_gnt), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: every granted write is popped from the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && bus_req && bus_gnt) begin
            if (exp_q.size() == 0) begin
               check(0, "R3", "unexpected bus write", 64'(bus_addr), 64'hFFFF);
            end else begin
               logic [ADDR_W-1:0] ea;
               ea = exp_q.pop_front();
               check(bus_addr == ea, "R2 R4", "drain address", 64'(bus_addr), 64'(ea));
               check(rd_en && rd_addr == bus_addr, "R7", "cache read address", 64'(rd_addr), 64'(bus_addr));
               check(bus_data == cmem[ea[3:0]], "R7", "drain data", 64'(bus_data), 64'(cmem[ea[3:0]]));
               last_data = bus_data;
            end
         end
      end
   end

   // driver: present one request and hold it until accepted
   task automatic enq(input logic [ADDR_W-1:0] a, input bit expect_new);
      @(negedge clk);
      wb_valid = 1'b1;
      wb_addr  = a;
      #1;
      while (wb_stall) begin
         @(negedge clk);
         #1;
      end
      if (expect_new) exp_q.push_back(a);
      @(posedge clk);
      @(negedge clk);
      wb_valid = 1'b0;
   endtask

   task automatic drain(input int n);
      @(negedge clk);
      bus_gnt = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      bus_gnt = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) cmem[i] = 32'hA000_0000 + 32'(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(!wb_stall, "R1", "stall after reset", 64'(wb_stall), 0);
      check(!bus_req, "R1", "bus_req after reset", 64'(bus_req), 0);

      // R2: FIFO order of distinct addresses
      enq(8'h01, 1); enq(8'h02, 1); enq(8'h03, 1);
      #1;
      check(bus_req && bus_addr == 8'h01, "R2", "front address", 64'(bus_addr), 64'h01);
      drain(3);
      #1;
      // R3: all freed after three grants
      check(!bus_req, "R3", "bus_req after drain", 64'(bus_req), 0);
      check(exp_q.size() == 0, "R3", "writes outstanding", 64'(exp_q.size()), 0);

      // R4: repeat address combines
      enq(8'h04, 1); enq(8'h05, 1); enq(8'h04, 0);
      drain(3);
      #1;
      check(!bus_req, "R4", "bus_req after combine drain", 64'(bus_req), 0);
      check(exp_q.size() == 0, "R4", "writes outstanding", 64'(exp_q.size()), 0);

      // fill the queue
      enq(8'h10, 1); enq(8'h11, 1); enq(8'h12, 1); enq(8'h13, 1);
      @(negedge clk);
      wb_valid = 1'b1; wb_addr = 8'h11;
      #1;
      // R6: combining request on a full queue
      check(!wb_stall, "R6", "stall on combine when full", 64'(wb_stall), 0);
      @(negedge clk);
      wb_addr = 8'h20;
      #1;
      // R5: new address on a full queue stalls
      check(wb_stall, "R5", "stall when full", 64'(wb_stall), 1);
      @(negedge clk);
      #1;
      check(wb_stall, "R5", "stall held while full", 64'(wb_stall), 1);
      @(negedge clk);
      bus_gnt = 1'b1;
      #1;
      // R8: grant frees a slot in the same cycle
      check(!wb_stall, "R8", "stall during grant", 64'(wb_stall), 0);
      exp_q.push_back(8'h20);
      @(posedge clk);
      @(negedge clk);
      wb_valid = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      bus_gnt = 1'b0;
      #1;
      check(!bus_req, "R5", "bus_req after full drain", 64'(bus_req), 0);
      check(exp_q.size() == 0, "R8", "writes outstanding", 64'(exp_q.size()), 0);

      // R7: line rewritten after queueing drains newest data
      enq(8'h07, 1);
      cmem[7] = 32'hBEEF_0007;
      drain(1);
      check(last_data == 32'hBEEF_0007, "R7", "newest data", 64'(last_data), 64'hBEEF_0007);

      // R9: request matching the front slot while it is granted
      enq(8'h30, 1);
      @(negedge clk);
      bus_gnt = 1'b1; wb_valid = 1'b1; wb_addr = 8'h30;
      #1;
      check(!wb_stall, "R9", "stall on leaving match", 64'(wb_stall), 0);
      exp_q.push_back(8'h30);
      @(posedge clk);
      @(negedge clk);
      bus_gnt = 1'b0; wb_valid = 1'b0;
      #1;
      check(bus_req && bus_addr == 8'h30, "R9", "second entry queued", 64'(bus_addr), 64'h30);
      drain(1);
      #1;
      check(!bus_req, "R9", "bus_req after second write", 64'(bus_req), 0);
      check(exp_q.size() == 0, "R9", "writes outstanding", 64'(exp_q.size()), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule